// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Rate Generator

This block derives a serial bit clock and a periodic frame-sync pulse for a synchronous serial port. Its source is either an internal reference or one of three external clock pins. The internal reference completes one cycle every two system clocks. A pin can have its sense inverted before use. All logic runs on one system clock. Each pin is passed through a two-flop synchronizer and then an edge detector. The selected source therefore becomes a stream of edge enables, and the block creates no derived clock.

Three cascaded stages follow the source. A half-period divider toggles the generated clock once for every `div_cfg + 1` source edges. The first generated high phase always starts on an active source edge. A frame counter counts generated-clock rising edges and restarts every `per_cfg + 1` of them. A width stage holds the frame sync high for the first `wid_cfg + 1` generated cycles of each frame. If the width is not shorter than the period, the frame sync stays high. Any change to a configuration input restarts every stage, as a reset would.

Top module: `serial_rate_gen`

## Requirements
- R1: While `rst` is high, `gen_clk` and `frame_sync` are 0. On the clock edge that samples a changed configuration input, both outputs go to 0 and all stages restart.
- R2: `src_sel` picks the source: 0 is the internal reference, 1 is `ck_pin_a`, 2 is `ck_pin_b` and 3 is `ck_pin_c`. Activity on a pin that is not selected leaves both outputs unchanged.
- R3: `pin_inv` bit 0, 1 or 2 inverts pin a, b or c respectively. Only the bit of the selected pin has an effect. Without inversion, a rising pin edge is the active edge; with inversion, a falling pin edge is. The first `gen_clk` rise after a restart occurs on the third system-clock edge after the first active pin edge, counting the edge that first samples the new pin level.
- R4: When `force_rise` is 1, every `pin_inv` bit is ignored and the rising pin edge is active.
- R5: With the internal source, `gen_clk` first rises on the second clock edge after the edge that ends reset or applies a restart. After that, each high phase and each low phase lasts `div_cfg + 1` system clocks, so `gen_clk` never runs faster than half the system clock.
- R6: With a pin source, every pin edge is a source edge. After the first active edge, `gen_clk` toggles once for every `div_cfg + 1` source edges. When `div_cfg` is 0, `gen_clk` follows the pin, delayed by the synchronizer.
- R7: The rising edges of `gen_clk` are numbered from 0, starting at the first rise after a restart. Edge k begins frame `k / (per_cfg + 1)`. `frame_sync` changes only on the system-clock edge where `gen_clk` rises, or at a reset or restart.
- R8: On generated rising edge k, `frame_sync` becomes 1 if `k mod (per_cfg + 1)` is at most `wid_cfg`, and 0 otherwise. This gives a pulse `wid_cfg + 1` generated cycles wide.
- R9: When `wid_cfg >= per_cfg`, `frame_sync` stays at 1 from the first generated rise until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ck_pin_a | input | 1 | External clock pin a (asynchronous) |
| ck_pin_b | input | 1 | External clock pin b (asynchronous) |
| ck_pin_c | input | 1 | External clock pin c (asynchronous) |
| src_sel | input | 2 | Source select: 0 internal, 1 pin a, 2 pin b, 3 pin c |
| pin_inv | input | 3 | Per-pin inversion, bit i for pin a/b/c |
| force_rise | input | 1 | Ignore inversion bits; rising edge is active |
| div_cfg | input | 8 | Half-period length in source edges, minus 1 |
| per_cfg | input | 12 | Frame period in generated cycles, minus 1 |
| wid_cfg | input | 8 | Frame-sync width in generated cycles, minus 1 |
| gen_clk | output | 1 | Generated serial bit clock |
| frame_sync | output | 1 | Generated frame-sync pulse |

## Verification
The internal-source sweep covers every divider, period and width setting in a small grid. It includes a period of one generated cycle and widths both below and at or above the period. A design that counted the frame off by one, stretched the pulse, or failed to hold the sync high in the wide case would produce a wrong cycle-exact waveform. Each sweep step is applied as a configuration change without reset. This exposes a design that fails to restart, or that carries a stale count across the change. The pin cases start the divider on a non-active first pin edge, and they toggle only an unselected pin. A design that ignored polarity, applied the wrong pin's inversion bit, honoured inversion under `force_rise`, or leaked a foreign pin into the divider would move its first generated edge or toggle at all.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_PINA = 2'd1,
        SRC_PINB = 2'd2,
        SRC_PINC = 2'd3
    } src_e;

    localparam int unsigned NUM_PINS = 3;

endpackage

// File: rtl/rg_source.sv
// Source stage: pin synchronizers, internal reference, polarity and edge detect.
module rg_source
    import rg_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reload_i,
    input  logic [NUM_PINS-1:0] pins_i,
    input  src_e                sel_i,
    input  logic [NUM_PINS-1:0] inv_i,
    input  logic                force_rise_i,
    output logic                tick_o,
    output logic                rise_o
);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0][NUM_PINS-1:0] syn;
        logic                                refc;
        logic                                prev;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    lvl;
    logic [NUM_PINS-1:0] pin_lvl;

    always_comb begin
        st_d = st_q;
        st_d.syn[0] = pins_i;
        for (int i = 1; i < int'(SYNC_DEPTH); i++) begin
            st_d.syn[i] = st_q.syn[i-1];
        end
        pin_lvl = st_q.syn[SYNC_DEPTH-1] ^ (inv_i & {NUM_PINS{~force_rise_i}});
        unique case (sel_i)
            SRC_INT:  lvl = st_q.refc;
            SRC_PINA: lvl = pin_lvl[0];
            SRC_PINB: lvl = pin_lvl[1];
            default:  lvl = pin_lvl[2];
        endcase
        st_d.refc = reload_i ? 1'b0 : ~st_q.refc;
        st_d.prev = lvl;
        tick_o    = lvl ^ st_q.prev;
        rise_o    = lvl & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R5: the internal reference yields an edge on every cycle once settled
    a_r5_int_tick_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SRC_INT && $past(sel_i) == SRC_INT && !reload_i
         && !$past(reload_i) && !$past(rst)) |-> tick_o);

endmodule

// File: rtl/rg_divider.sv
// Half-period divider: toggles the generated clock every DIV+1 source edges.
module rg_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_i,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             gclk_o,
    output logic             grise_o
);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] hcnt;
        logic             gclk;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        grise_o = 1'b0;
        if (reload_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (!st_q.run) begin
                if (rise_i) begin
                    st_d.run  = 1'b1;
                    st_d.gclk = 1'b1;
                    st_d.hcnt = '0;
                    grise_o   = 1'b1;
                end
            end else if (st_q.hcnt == div_i) begin
                st_d.hcnt = '0;
                st_d.gclk = ~st_q.gclk;
                grise_o   = ~st_q.gclk;
            end else begin
                st_d.hcnt = st_q.hcnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gclk_o = st_q.gclk;

    // R6: the generated clock only moves after a source edge or a restart
    a_r6_gclk_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st_q.gclk != $past(st_q.gclk)) |-> $past(tick_i || reload_i));

    // R6: half-period count never passes the programmed limit
    a_r6_hcnt_bound: assert property (@(posedge clk) disable iff (rst)
        !reload_i |-> (st_q.hcnt <= div_i));

endmodule

// File: rtl/rg_frame.sv
// Frame period counter and frame-sync width stage, clocked by generated rises.
module rg_frame #(
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_i,
    input  logic             grise_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [WID_W-1:0] wid_i,
    output logic             fsync_o
);

    localparam int unsigned CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] fcnt;
        logic             fs;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [PER_W-1:0] nxt;
    logic [CMP_W-1:0] nxt_x, wid_x, per_x;

    assign wid_x = CMP_W'(wid_i);
    assign per_x = CMP_W'(per_i);

    always_comb begin
        st_d  = st_q;
        nxt   = (st_q.fcnt == per_i) ? '0 : st_q.fcnt + PER_W'(1);
        nxt_x = CMP_W'(nxt);
        if (reload_i) begin
            st_d = '0;
        end else if (grise_i) begin
            if (!st_q.run) begin
                st_d.run  = 1'b1;
                st_d.fcnt = '0;
                st_d.fs   = 1'b1;
            end else begin
                st_d.fcnt = nxt;
                st_d.fs   = (nxt_x <= wid_x);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fsync_o = st_q.fs;

    // R7: frame sync moves only with a generated rise or a restart
    a_r7_fs_on_grise: assert property (@(posedge clk) disable iff (rst)
        (st_q.fs != $past(st_q.fs)) |-> $past(grise_i || reload_i));

    // R7: frame position stays inside the programmed period
    a_r7_fcnt_bound: assert property (@(posedge clk) disable iff (rst)
        !reload_i |-> (st_q.fcnt <= per_i));

    // R9: a width not shorter than the period keeps the sync high
    a_r9_wide_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && (wid_x >= per_x) && !reload_i) |-> st_q.fs);

endmodule

// File: rtl/serial_rate_gen.sv
// Top: configuration-change restart and the three cascaded stages.
module serial_rate_gen
    import rg_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned PER_W      = 12,
    parameter int unsigned WID_W      = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ck_pin_a,
    input  logic             ck_pin_b,
    input  logic             ck_pin_c,
    input  logic [1:0]       src_sel,
    input  logic [2:0]       pin_inv,
    input  logic             force_rise,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [PER_W-1:0] per_cfg,
    input  logic [WID_W-1:0] wid_cfg,
    output logic             gen_clk,
    output logic             frame_sync
);

    typedef struct packed {
        logic [1:0]       sel;
        logic [2:0]       inv;
        logic             frc;
        logic [DIV_W-1:0] dv;
        logic [PER_W-1:0] pr;
        logic [WID_W-1:0] wd;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic reload, tick, rise, grise;

    always_comb begin
        cfg_d  = '{sel: src_sel, inv: pin_inv, frc: force_rise,
                   dv: div_cfg, pr: per_cfg, wd: wid_cfg};
        reload = (cfg_d != cfg_q);
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    rg_source #(.SYNC_DEPTH(SYNC_DEPTH)) u_src (
        .clk          (clk),
        .rst          (rst),
        .reload_i     (reload),
        .pins_i       ({ck_pin_c, ck_pin_b, ck_pin_a}),
        .sel_i        (src_e'(src_sel)),
        .inv_i        (pin_inv),
        .force_rise_i (force_rise),
        .tick_o       (tick),
        .rise_o       (rise)
    );

    rg_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .reload_i (reload),
        .tick_i   (tick),
        .rise_i   (rise),
        .div_i    (div_cfg),
        .gclk_o   (gen_clk),
        .grise_o  (grise)
    );

    rg_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk      (clk),
        .rst      (rst),
        .reload_i (reload),
        .grise_i  (grise),
        .per_i    (per_cfg),
        .wid_i    (wid_cfg),
        .fsync_o  (frame_sync)
    );

    // R1: outputs are low right after reset
    a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!gen_clk && !frame_sync));

    // R1: outputs are low right after a configuration change
    a_r1_reload_low: assert property (@(posedge clk) disable iff (rst)
        $past(reload) |-> (!gen_clk && !frame_sync));

endmodule

// File: tb/serial_rate_gen_test.sv
module serial_rate_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  pins = 3'b000;
    logic [1:0]  src_sel = 2'd0;
    logic [2:0]  pin_inv = 3'b000;
    logic        force_rise = 1'b0;
    logic [7:0]  div_cfg = 8'd1;
    logic [11:0] per_cfg = 12'd2;
    logic [7:0]  wid_cfg = 8'd0;
    logic        gen_clk, frame_sync;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    serial_rate_gen uut (
        .clk        (clk),
        .rst        (rst),
        .ck_pin_a   (pins[0]),
        .ck_pin_b   (pins[1]),
        .ck_pin_c   (pins[2]),
        .src_sel    (src_sel),
        .pin_inv    (pin_inv),
        .force_rise (force_rise),
        .div_cfg    (div_cfg),
        .per_cfg    (per_cfg),
        .wid_cfg    (wid_cfg),
        .gen_clk    (gen_clk),
        .frame_sync (frame_sync)
    );

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Internal-source waveform model, c = edges since the restart edge
    task automatic run_int(input int d, input int p, input int w, input int ncyc);
        for (int c = 1; c <= ncyc; c++) begin
            int eg, ef, k;
            @(posedge clk); #1;
            if (c < 2) begin
                eg = 0; ef = 0;
            end else begin
                eg = (((c - 2) / (d + 1)) % 2 == 0) ? 1 : 0;
                k  = (c - 2) / (2 * (d + 1));
                ef = ((k % (p + 1)) <= w) ? 1 : 0;
            end
            chk(int'(gen_clk), eg, "R5 gen_clk");
            chk(int'(frame_sync), ef, (w >= p) ? "R9 frame_sync" : "R7/R8 frame_sync");
        end
    endtask

    // Pin-source case: toggle pin drv every H cycles; sel/inv/frc as given
    task automatic pin_case(input int sel, input logic [2:0] inv, input logic frc,
                            input int d, input int drv, input string tag);
        int H, t0, ncyc, effinv;
        bit ign;
        H = 4;
        ign = (sel != drv + 1);
        effinv = frc ? 0 : int'(inv[drv]);
        t0 = (effinv != 0) ? 2 : 1;
        ncyc = H * (t0 + 4 * (d + 1) + 1) + 2;
        @(negedge clk);
        pins = 3'b000;
        repeat (4) @(negedge clk);
        src_sel = 2'(sel); pin_inv = inv; force_rise = frc;
        div_cfg = 8'(d); per_cfg = 12'd3; wid_cfg = 8'd0;
        @(posedge clk); #1;
        chk(int'(gen_clk), 0, {tag, " restart"});
        for (int c = 1; c <= ncyc; c++) begin
            int eg, tl;
            @(negedge clk);
            if (c % H == 0) pins[drv] = ~pins[drv];
            @(posedge clk); #1;
            tl = (c >= 2) ? (c - 2) / H : 0;
            if (ign || c < 2 || tl < t0) eg = 0;
            else eg = ((((tl - t0) / (d + 1)) % 2) == 0) ? 1 : 0;
            chk(int'(gen_clk), eg, tag);
            if (ign) chk(int'(frame_sync), 0, tag);
        end
        @(negedge clk);
        pins = 3'b000;
    endtask

    initial begin
        // R1: reset holds outputs low
        repeat (3) begin
            @(posedge clk); #1;
            chk(int'(gen_clk), 0, "R1 reset gen_clk");
            chk(int'(frame_sync), 0, "R1 reset frame_sync");
        end
        @(negedge clk);
        rst = 1'b0;
        run_int(1, 2, 0, 40);

        // Sweep of internal-source settings, each applied as a restart (R1)
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 6; p++) begin
                for (int w = 0; w < 7; w++) begin
                    @(negedge clk);
                    src_sel = 2'd0; pin_inv = 3'b000; force_rise = 1'b0;
                    div_cfg = 8'(d); per_cfg = 12'(p); wid_cfg = 8'(w);
                    @(posedge clk); #1;
                    chk(int'(gen_clk), 0, "R1 restart gen_clk");
                    chk(int'(frame_sync), 0, "R1 restart frame_sync");
                    run_int(d, p, w, 4 * (d + 1) * (p + 1) + 4);
                end
            end
        end

        // Pin sources
        pin_case(1, 3'b000, 1'b0, 0, 0, "R6 pin a pass-through");
        pin_case(2, 3'b010, 1'b0, 1, 1, "R3 pin b inverted");
        pin_case(1, 3'b110, 1'b0, 2, 0, "R3 foreign inv bit");
        pin_case(3, 3'b100, 1'b1, 2, 2, "R4 force_rise");
        pin_case(3, 3'b000, 1'b0, 1, 0, "R2 unselected pin a");
        pin_case(2, 3'b000, 1'b1, 0, 2, "R2 unselected pin c");
        pin_case(3, 3'b000, 1'b0, 3, 2, "R6 pin c divide");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule